// File: doc/BRIEF.md
# Bus Cycle Sequencer

This block runs the external bus cycles of a processor core whose data path is 64 bits wide. The core hands it one transfer at a time, which carries a qualword-aligned address, byte enables, write data and the qualifiers that mark the cycle as memory or IO, read or write, and data or code. The sequencer opens the cycle with a one-clock address strobe. It then waits on the active-low ready input, and each clock that ends without ready is a wait state. When the external side accepts a cacheable memory read as cacheable, the read becomes a line fill of several beats.

The bus can be taken away in two ways. A hold request is orderly: the cycle in flight runs to its end, the bus outputs float, and only then is the acknowledge raised. A back-off is abrupt: the cycle in flight is abandoned at once, the core sees an abort pulse, and the same transfer starts again from its first beat once back-off is removed. A locked read-modify-write pair keeps the lock output low from the first cycle to the end of the second, and hold is not granted between the two halves.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the bus is floating (`bus_oe`=0), `ads_n`=1, `bus_lock_n`=1, `bus_breq`=0, `bus_hlda`=0, and `req_ready`=1.
- R2: An accepted request produces an address strobe (`ads_n` low) lasting exactly one clock, with `bus_oe`=1. During the strobe the bus shows the request's address, `bus_be_n` as the inverse of `req_be`, `bus_mio`=req_mem, `bus_wr`=req_write and `bus_dc`=req_data.
- R3: In the data phase, a clock with `rdy_n` high is a wait state and raises neither `done` nor `rdata_valid`. A clock with `rdy_n` low ends the beat; on a read it raises `rdata_valid` with `rdata` equal to `bus_rdata`.
- R4: On a write, `bus_wdata` holds the request's write data in every byte lane whose enable bit is set (bit b covers bits 8b+7..8b) and holds zero in every other lane.
- R5: A read with req_mem=1 and req_cacheable=1 that finds `cen_n` low on the clock of its first ready becomes a line fill of LINE_BEATS (4) beats, each ended by its own ready, and `done` is raised only with the last one. Every other cycle (a write, an IO read, a non-cacheable read, or `cen_n` high) ends with its first ready.
- R6: A hold that arrives during a cycle does not cut it short. `bus_hlda` rises only after `done`, at a point where the bus is already floating, and falls once hold is removed. No address strobe occurs while `bus_hlda` is high.
- R7: When `boff_n` is low while the bus is driven, `abort` is raised in that clock, a ready in the same clock is ignored (no `done`, no `rdata_valid`), and from the next clock the bus floats with no strobe for as long as `boff_n` stays low.
- R8: An aborted transfer stays pending and is reissued with a fresh address strobe after `boff_n` returns high. It restarts at its first beat, so a reissued line fill again needs LINE_BEATS ready beats.
- R9: A request with req_lock=1 drives `bus_lock_n` low from its address strobe until the next request with req_lock=0 completes. While `bus_lock_n` is low, hold is not acknowledged.
- R10: `bus_breq` is high from the clock after a request is accepted until that request completes, including while hold or back-off keeps the cycle from starting.
- R11: `req_ready` is low while a request is pending, so a single transfer is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Sequencer can take a transfer |
| req_addr | input | ADDR_W | Qualword address of the transfer |
| req_be | input | DATA_W/8 | Byte-lane enables, active high |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = IO |
| req_data | input | 1 | 1 = data, 0 = code |
| req_cacheable | input | 1 | Core may cache the line |
| req_lock | input | 1 | First half of a locked pair |
| done | output | 1 | Transfer complete (pulse) |
| abort | output | 1 | Transfer abandoned by back-off (pulse) |
| rdata | output | DATA_W | Read data of the current beat |
| rdata_valid | output | 1 | A read beat is accepted |
| bus_addr | output | ADDR_W | Bus address |
| bus_be_n | output | DATA_W/8 | Bus byte enables, active low |
| bus_wdata | output | DATA_W | Bus write data |
| bus_oe | output | 1 | Bus outputs driven (0 = floating) |
| ads_n | output | 1 | Address strobe, active low |
| bus_mio | output | 1 | 1 = memory cycle, 0 = IO cycle |
| bus_wr | output | 1 | 1 = write cycle |
| bus_dc | output | 1 | 1 = data cycle, 0 = code |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_breq | output | 1 | A cycle is waiting or running |
| bus_hlda | output | 1 | Hold acknowledge |
| bus_rdata | input | DATA_W | Bus read data |
| rdy_n | input | 1 | Bus ready, active low |
| boff_n | input | 1 | Back-off, active low |
| hold | input | 1 | Hold request |
| cen_n | input | 1 | Cache enable, active low |

## Verification
The hardest case to reach is a back-off that lands in the middle of a line fill, after some beats are already done, in the same clock as a ready. The stimulus starts a cacheable read and grants the fill with `cen_n`, returns two beats, and then drives ready and back-off low together. It keeps back-off low for several clocks and then follows the reissue to confirm that four fresh beats are needed. A second hard case is hold arriving between the halves of a locked pair: the stimulus raises hold right after the locked read and holds it through the unlocked write, to show that the acknowledge waits for the lock to drop.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_HELD,
      ST_BOFF
   } bcs_state_e;
endpackage

// File: rtl/bcs_beat_ctr.sv
`timescale 1ns/1ps
module bcs_beat_ctr #(
   parameter int LINE_BEATS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic fill_ok,
   output logic last
);
   localparam int CNT_W = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_BEATS - 1);

   logic [CNT_W-1:0] cnt_q;

   // On the first beat the fill decision comes straight from the enable input;
   // after that only the beat number matters.
   assign last = (cnt_q == '0) ? !fill_ok : (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= last ? '0 : cnt_q + 1'b1;
   end

   // R5
   fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && cnt_q == CNT_LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/bcs_lock_trk.sv
`timescale 1ns/1ps
module bcs_lock_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_lock,
   input  logic finish,
   input  logic finish_lock,
   output logic lock_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_on <= 1'b0;
      else if (start && start_lock)
         lock_on <= 1'b1;
      else if (finish && !finish_lock)
         lock_on <= 1'b0;
   end

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_on && !finish) |=> lock_on);
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq #(
   parameter int ADDR_W     = 29,
   parameter int DATA_W     = 64,
   parameter int LINE_BEATS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W/8-1:0]  req_be,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic                 req_write,
   input  logic                 req_mem,
   input  logic                 req_data,
   input  logic                 req_cacheable,
   input  logic                 req_lock,
   output logic                 done,
   output logic                 abort,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_valid,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [DATA_W/8-1:0]  bus_be_n,
   output logic [DATA_W-1:0]    bus_wdata,
   output logic                 bus_oe,
   output logic                 ads_n,
   output logic                 bus_mio,
   output logic                 bus_wr,
   output logic                 bus_dc,
   output logic                 bus_lock_n,
   output logic                 bus_breq,
   output logic                 bus_hlda,
   input  logic [DATA_W-1:0]    bus_rdata,
   input  logic                 rdy_n,
   input  logic                 boff_n,
   input  logic                 hold,
   input  logic                 cen_n
);
   import bcs_pkg::*;

   localparam int BE_W = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("bus_cycle_seq: DATA_W must be a whole number of bytes");
      end
      if (LINE_BEATS < 2 || (LINE_BEATS & (LINE_BEATS - 1)) != 0) begin : g_bad_beats
         $error("bus_cycle_seq: LINE_BEATS must be a power of two, at least 2");
      end
   endgenerate

   bcs_state_e          state_q, state_d;
   logic                pend_q;
   logic [ADDR_W-1:0]   p_addr;
   logic [BE_W-1:0]     p_be;
   logic [DATA_W-1:0]   p_wdata;
   logic                p_write, p_mem, p_data, p_cache, p_lock;

   logic accept, on_bus, backoff, beat, last, fill_ok, lock_on, start;

   assign accept  = req_valid && !pend_q;
   assign on_bus  = (state_q == ST_ADDR) || (state_q == ST_DATA);
   assign backoff = !boff_n;
   assign beat    = (state_q == ST_DATA) && !rdy_n && !backoff;
   assign fill_ok = !p_write && p_mem && p_cache && !cen_n;
   assign start   = (state_q == ST_IDLE) && (state_d == ST_ADDR);

   // request holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         p_addr  <= '0;
         p_be    <= '0;
         p_wdata <= '0;
         p_write <= 1'b0;
         p_mem   <= 1'b0;
         p_data  <= 1'b0;
         p_cache <= 1'b0;
         p_lock  <= 1'b0;
      end else if (accept) begin
         pend_q  <= 1'b1;
         p_addr  <= req_addr;
         p_be    <= req_be;
         p_wdata <= req_wdata;
         p_write <= req_write;
         p_mem   <= req_mem;
         p_data  <= req_data;
         p_cache <= req_cacheable;
         p_lock  <= req_lock;
      end else if (done) begin
         pend_q  <= 1'b0;
      end
   end

   // cycle sequencing
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (backoff)
               state_d = ST_IDLE;
            else if (hold && !lock_on)
               state_d = ST_HELD;
            else if (pend_q)
               state_d = ST_ADDR;
         end
         ST_ADDR: state_d = backoff ? ST_BOFF : ST_DATA;
         ST_DATA: begin
            if (backoff)
               state_d = ST_BOFF;
            else if (done)
               state_d = ST_IDLE;
         end
         ST_HELD: if (!hold)    state_d = ST_IDLE;
         ST_BOFF: if (!backoff) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   bcs_beat_ctr #(.LINE_BEATS(LINE_BEATS)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (abort),
      .step    (beat),
      .fill_ok (fill_ok),
      .last    (last)
   );

   bcs_lock_trk u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_lock  (p_lock),
      .finish      (done),
      .finish_lock (p_lock),
      .lock_on     (lock_on)
   );

   // write lanes: disabled bytes are driven as zero
   generate
      for (genvar b = 0; b < BE_W; b++) begin : g_lane
         assign bus_wdata[8*b +: 8] = p_be[b] ? p_wdata[8*b +: 8] : 8'h00;
      end
   endgenerate

   assign req_ready   = !pend_q;
   assign done        = beat && last;
   assign abort       = on_bus && backoff;
   assign rdata       = bus_rdata;
   assign rdata_valid = beat && !p_write;
   assign bus_addr    = p_addr;
   assign bus_be_n    = ~p_be;
   assign bus_oe      = on_bus;
   assign ads_n       = (state_q != ST_ADDR);
   assign bus_mio     = p_mem;
   assign bus_wr      = p_write;
   assign bus_dc      = p_data;
   assign bus_lock_n  = !lock_on;
   assign bus_breq    = pend_q;
   assign bus_hlda    = (state_q == ST_HELD);

   // R2
   ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ads_n |=> ads_n);

   // R6
   hlda_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_hlda) |-> ($past(hold) && !$past(bus_oe)));

   // R7
   boff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !boff_n) |=> (!bus_oe && ads_n));

   // R9
   lock_no_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_lock_n |-> !bus_hlda);

   // R10
   breq_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> bus_breq);
endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
   localparam int ADDR_W = 29;
   localparam int DATA_W = 64;
   localparam int BE_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              req_valid = 0, req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [BE_W-1:0]   req_be = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_write = 0, req_mem = 0, req_data = 0, req_cacheable = 0, req_lock = 0;
   logic done, abort, rdata_valid;
   logic [DATA_W-1:0] rdata, bus_wdata;
   logic [ADDR_W-1:0] bus_addr;
   logic [BE_W-1:0]   bus_be_n;
   logic bus_oe, ads_n, bus_mio, bus_wr, bus_dc, bus_lock_n, bus_breq, bus_hlda;
   logic [DATA_W-1:0] bus_rdata = '0;
   logic rdy_n = 1, boff_n = 1, hold = 0, cen_n = 1;

   int checks = 0;
   int errors = 0;

   bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BEATS(4)) u_bus_cycle_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_write(req_write), .req_mem(req_mem), .req_data(req_data),
      .req_cacheable(req_cacheable), .req_lock(req_lock), .done(done),
      .abort(abort), .rdata(rdata), .rdata_valid(rdata_valid),
      .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
      .bus_oe(bus_oe), .ads_n(ads_n), .bus_mio(bus_mio), .bus_wr(bus_wr),
      .bus_dc(bus_dc), .bus_lock_n(bus_lock_n), .bus_breq(bus_breq),
      .bus_hlda(bus_hlda), .bus_rdata(bus_rdata), .rdy_n(rdy_n),
      .boff_n(boff_n), .hold(hold), .cen_n(cen_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [ADDR_W-1:0] a, input logic [BE_W-1:0] be,
                        input logic [63:0] wd, input logic wr, input logic mem,
                        input logic dat, input logic cch, input logic lck);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_be = be; req_wdata = wd;
      req_write = wr; req_mem = mem; req_data = dat; req_cacheable = cch; req_lock = lck;
      #1 chk("R11", "req_ready before accept", req_ready, 1);
      @(negedge clk);
      req_valid = 0;
   endtask

   // returns at a falling edge in the strobe clock
   task automatic wait_ads();
      for (int i = 0; i < 12 && ads_n; i++) @(negedge clk);
      chk("R2", "strobe seen", ads_n, 0);
   endtask

   // called at a falling edge in the data phase; returns one falling edge after the beat
   task automatic beat(input int waits, input logic [63:0] rd,
                       output logic got_done, output logic got_rv);
      for (int i = 0; i < waits; i++) begin
         rdy_n = 1;
         #1 chk("R3", "no done in wait state", {done, rdata_valid}, 0);
         @(negedge clk);
      end
      rdy_n = 0; bus_rdata = rd;
      #1 got_done = done; got_rv = rdata_valid;
      if (rdata_valid) chk("R3", "read data", rdata, rd);
      @(negedge clk);
      rdy_n = 1;
   endtask

   task automatic t_reset();
      chk("R1", "bus_oe", bus_oe, 0);
      chk("R1", "ads_n", ads_n, 1);
      chk("R1", "lock_n", bus_lock_n, 1);
      chk("R1", "breq", bus_breq, 0);
      chk("R1", "hlda", bus_hlda, 0);
      chk("R1", "req_ready", req_ready, 1);
   endtask

   task automatic t_single_read();
      logic d, v;
      issue(29'h0ABCDE1, 8'h3C, 64'h0, 0, 1, 1, 0, 0);
      chk("R10", "breq pending", bus_breq, 1);
      chk("R11", "req_ready pending", req_ready, 0);
      wait_ads();
      chk("R2", "addr", bus_addr, 29'h0ABCDE1);
      chk("R2", "be_n", bus_be_n, 8'hC3);
      chk("R2", "mio/wr/dc", {bus_mio, bus_wr, bus_dc}, 3'b101);
      chk("R2", "oe", bus_oe, 1);
      @(negedge clk);
      chk("R2", "strobe one clock", ads_n, 1);
      beat(2, 64'hDEAD_BEEF_0123_4567, d, v);
      chk("R3", "done on ready", d, 1);
      chk("R3", "rdata_valid", v, 1);
      chk("R2", "float after", bus_oe, 0);
      chk("R10", "breq cleared", bus_breq, 0);
   endtask

   task automatic t_fill();
      logic d, v;
      int nv;
      issue(29'h0000100, 8'hFF, 64'h0, 0, 1, 0, 1, 0);
      wait_ads();
      chk("R2", "code cycle dc", bus_dc, 0);
      @(negedge clk);
      cen_n = 0;
      beat(1, 64'h1, d, v); nv = int'(v);
      chk("R5", "beat1 not last", d, 0);
      cen_n = 1;
      for (int k = 2; k <= 3; k++) begin
         beat(0, 64'(k), d, v); nv += int'(v);
         chk("R5", "middle beat not last", d, 0);
      end
      beat(2, 64'h4, d, v); nv += int'(v);
      chk("R5", "fourth beat last", d, 1);
      chk("R5", "four read beats", nv, 4);
   endtask

   task automatic t_no_fill();
      logic d, v;
      issue(29'h0000200, 8'hFF, 64'h0, 0, 1, 1, 1, 0);
      wait_ads(); @(negedge clk);
      beat(0, 64'h55, d, v);
      chk("R5", "cen_n high single beat", d, 1);
      issue(29'h0000300, 8'hFF, 64'h0, 0, 0, 1, 1, 0);
      wait_ads();
      chk("R2", "io cycle mio", bus_mio, 0);
      @(negedge clk);
      cen_n = 0;
      beat(0, 64'h66, d, v);
      cen_n = 1;
      chk("R5", "io read single beat", d, 1);
   endtask

   task automatic t_hold();
      logic d, v;
      issue(29'h0000400, 8'hFF, 64'h0, 0, 1, 1, 0, 0);
      wait_ads(); @(negedge clk);
      hold = 1;
      beat(3, 64'h77, d, v);
      chk("R6", "cycle finished under hold", d, 1);
      chk("R6", "no hlda yet", bus_hlda, 0);
      chk("R6", "bus floating", bus_oe, 0);
      @(negedge clk);
      chk("R6", "hlda raised", bus_hlda, 1);
      chk("R6", "floating while held", bus_oe, 0);
      issue(29'h0000500, 8'hFF, 64'h0, 0, 1, 1, 0, 0);
      chk("R10", "breq while held", bus_breq, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R6", "no strobe while held", ads_n, 1);
      end
      hold = 0;
      @(negedge clk);
      chk("R6", "hlda dropped", bus_hlda, 0);
      wait_ads(); @(negedge clk);
      beat(0, 64'h88, d, v);
      chk("R6", "held request completes", d, 1);
   endtask

   task automatic t_backoff();
      logic d, v;
      int nads;
      issue(29'h0000600, 8'hFF, 64'h0, 0, 1, 1, 1, 0);
      wait_ads(); @(negedge clk);
      cen_n = 0;
      beat(0, 64'hA1, d, v);
      cen_n = 1;
      beat(0, 64'hA2, d, v);
      rdy_n = 0; boff_n = 0;
      #1;
      chk("R7", "abort pulse", abort, 1);
      chk("R7", "ready ignored", {done, rdata_valid}, 0);
      @(negedge clk);
      rdy_n = 1;
      chk("R7", "floated", bus_oe, 0);
      #1 chk("R7", "abort only on bus", abort, 0);
      nads = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         nads += int'(!ads_n || bus_oe);
      end
      chk("R7", "quiet during backoff", nads, 0);
      chk("R8", "still pending", bus_breq, 1);
      boff_n = 1;
      wait_ads();
      chk("R8", "reissue addr", bus_addr, 29'h0000600);
      @(negedge clk);
      cen_n = 0;
      beat(0, 64'hB1, d, v);
      cen_n = 1;
      chk("R8", "restart beat1 not last", d, 0);
      beat(0, 64'hB2, d, v);
      beat(0, 64'hB3, d, v);
      chk("R8", "restart beat3 not last", d, 0);
      beat(0, 64'hB4, d, v);
      chk("R8", "restart beat4 last", d, 1);
   endtask

   task automatic t_lock();
      logic d, v;
      issue(29'h0000700, 8'hFF, 64'h0, 0, 1, 1, 0, 1);
      wait_ads();
      chk("R9", "lock on at strobe", bus_lock_n, 0);
      @(negedge clk);
      beat(0, 64'hC1, d, v);
      chk("R9", "locked read done", d, 1);
      hold = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R9", "no hlda between halves", bus_hlda, 0);
         chk("R9", "lock kept between halves", bus_lock_n, 0);
      end
      issue(29'h0000700, 8'h0F, 64'h1122_3344_5566_7788, 1, 1, 1, 0, 0);
      wait_ads();
      chk("R4", "write qualifier", bus_wr, 1);
      chk("R4", "lane-masked write data", bus_wdata, 64'h0000_0000_5566_7788);
      @(negedge clk);
      beat(1, 64'h0, d, v);
      chk("R9", "write half done", d, 1);
      chk("R3", "no read beat on write", v, 0);
      chk("R9", "lock released", bus_lock_n, 1);
      @(negedge clk);
      chk("R9", "hold granted after lock", bus_hlda, 1);
      hold = 0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single_read();
      t_fill();
      t_no_fill();
      t_hold();
      t_backoff();
      t_lock();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule